// File: doc/BRIEF.md
# Register Scoreboard Wakeup Tracker

This block keeps, for a small out-of-order instruction window, a one-bit "value available" scoreboard for every physical register, together with the per-slot pending-operand state that decides when a waiting instruction may be picked for issue. An instruction is written into a slot together with its source tags, a readiness hint for each source from the rename stage, and an optional destination tag. Sources that are still outstanding are recorded as pending. A producer finishing its work broadcasts its destination tag. The broadcast clears the matching pending operands in every slot and marks the register available in the scoreboard.

Each slot drives one registered ready flag towards the issue selector. The flag is high while the slot holds an instruction whose sources are all available. A squash mask removes slots, and a removed slot can never be woken again. The insert path looks at the scoreboard and at a broadcast in the same cycle. An operand whose producer finished while the instruction was on its way to the window is therefore not left waiting. Tags at or above the physical register count stand for registers this block does not track. Such tags are passed over everywhere.

Top module: `wakeup_tracker`

## Requirements
- R1: While `rst` is high and in the cycle after it, every bit of `entry_ready` is 0, and every scoreboard bit reads not-available. An inserted source with a not-ready hint and a tag below 64 therefore waits until a broadcast.
- R2: An insert whose source hints (`ins_src_rdy`, bit s for source s) are all 1 raises `entry_ready[ins_slot]` after the insert clock edge.
- R3: A source inserted with hint 0 counts as available at once if its scoreboard bit is set. Otherwise the slot waits on that tag.
- R4: An insert with `ins_dst_valid` and a destination tag below 64 clears that tag's scoreboard bit. This applies even when a broadcast of the same tag happens in the same cycle, so a later consumer with hint 0 waits.
- R5: Tags of 64 or more are never tracked. Such a source counts as available. Such a destination leaves the scoreboard unchanged. A broadcast of such a tag changes nothing, including slots waiting on a tag with the same low six bits.
- R6: A broadcast (`cmp_valid`, `cmp_tag`) clears every matching pending operand in all occupied slots and sets the scoreboard bit. A slot that becomes complete raises its flag one cycle after the broadcast cycle. The flags change only through an insert, a broadcast or a squash.
- R7: A slot whose sources have only partly become available keeps `entry_ready` low.
- R8: Setting `sq_mask[i]` empties slot i and drops its flag after that edge, and a later broadcast does not wake it. An insert into the same slot in the same cycle takes priority over the squash.
- R9: A source inserted with hint 0 in the same cycle as a broadcast of its tag counts as available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Write an instruction into slot `ins_slot` |
| ins_slot | input | 4 | Target slot of the insert |
| ins_src_tag | input | 14 | Source tags, source s at bits [7s+6:7s] |
| ins_src_rdy | input | 2 | Rename hint per source, 1 = already available |
| ins_dst_valid | input | 1 | The inserted instruction writes a register |
| ins_dst_tag | input | 7 | Destination tag of the inserted instruction |
| cmp_valid | input | 1 | Completion broadcast strobe |
| cmp_tag | input | 7 | Destination tag of the finished producer |
| sq_mask | input | 16 | Bit i empties slot i |
| entry_ready | output | 16 | Bit i: slot i holds an instruction with all sources available |

## Verification
The bench builds the block with its default parameters: 64 tracked registers, 16 slots, two sources and 7-bit tags. The 7-bit tags give the bench a full set of untracked tags (64 to 127), which share their low six bits with tracked ones. Tag 64 against tag 0 is the case that exposes any truncating index. The tags, hints and squash masks are drawn to collide often on a small tag range. As a result, same-cycle insert and broadcast, squash and insert on one slot, and redefinition of a register while consumers wait all occur well inside the run.

// File: rtl/wt_pkg.sv
package wt_pkg;

  parameter int WT_PREGS_DFLT   = 64;
  parameter int WT_ENTRIES_DFLT = 16;
  parameter int WT_SRCS_DFLT    = 2;
  parameter int WT_TAG_W_DFLT   = 7;

  // A tag names a tracked register only when below the register count.
  function automatic logic wt_tracked(input logic [31:0] tag, input int npregs);
    return tag < 32'(npregs);
  endfunction

endpackage

// File: rtl/wt_scoreboard.sv
module wt_scoreboard
  import wt_pkg::*;
#(
  parameter int NUM_PREGS = WT_PREGS_DFLT,
  parameter int NUM_SRCS  = WT_SRCS_DFLT,
  parameter int TAG_W     = WT_TAG_W_DFLT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAG_W-1:0] look_tag [NUM_SRCS],
  output logic [NUM_SRCS-1:0] look_avail,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] clr_tag
);
  localparam int IDX_W = $clog2(NUM_PREGS);

  logic [NUM_PREGS-1:0] avail_q, avail_n;

  // Lookup: untracked tags count as available; a same-cycle set bypasses.
  always_comb begin
    for (int s = 0; s < NUM_SRCS; s++) begin
      if (!wt_tracked(32'(look_tag[s]), NUM_PREGS))
        look_avail[s] = 1'b1;
      else
        look_avail[s] = avail_q[look_tag[s][IDX_W-1:0]] |
                        (set_en && (set_tag == look_tag[s]));
    end
  end

  // A new producer's clear takes priority over a same-cycle set.
  always_comb begin
    avail_n = avail_q;
    if (set_en) avail_n[set_tag[IDX_W-1:0]] = 1'b1;
    if (clr_en) avail_n[clr_tag[IDX_W-1:0]] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) avail_q <= '0;
    else     avail_q <= avail_n;
  end

endmodule

// File: rtl/wt_entry.sv
module wt_entry
  import wt_pkg::*;
#(
  parameter int NUM_SRCS = WT_SRCS_DFLT,
  parameter int TAG_W    = WT_TAG_W_DFLT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ins_we,
  input  logic [TAG_W-1:0]    ins_tag [NUM_SRCS],
  input  logic [NUM_SRCS-1:0] ins_pend,
  input  logic                wake_en,
  input  logic [TAG_W-1:0]    wake_tag,
  input  logic                kill,
  output logic                rdy_o
);
  logic                valid_q, valid_n;
  logic [NUM_SRCS-1:0] pend_q, pend_n;
  logic [TAG_W-1:0]    tag_q [NUM_SRCS];

  always_comb begin
    valid_n = valid_q;
    pend_n  = pend_q;
    if (kill) begin
      valid_n = 1'b0;
      pend_n  = '0;
    end else if (wake_en) begin
      for (int s = 0; s < NUM_SRCS; s++)
        if (tag_q[s] == wake_tag) pend_n[s] = 1'b0;
    end
    if (ins_we) begin
      valid_n = 1'b1;
      pend_n  = ins_pend;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      pend_q  <= '0;
      rdy_o   <= 1'b0;
    end else begin
      valid_q <= valid_n;
      pend_q  <= pend_n;
      rdy_o   <= valid_n && (pend_n == '0);
    end
  end

  // Tags need no reset: they are only looked at while a pending bit is set.
  always_ff @(posedge clk) begin
    if (ins_we) tag_q <= ins_tag;
  end

endmodule

// File: rtl/wakeup_tracker.sv
module wakeup_tracker
  import wt_pkg::*;
#(
  parameter int NUM_PREGS   = WT_PREGS_DFLT,
  parameter int NUM_ENTRIES = WT_ENTRIES_DFLT,
  parameter int NUM_SRCS    = WT_SRCS_DFLT,
  parameter int TAG_W       = WT_TAG_W_DFLT,
  localparam int SLOT_W     = $clog2(NUM_ENTRIES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ins_valid,
  input  logic [SLOT_W-1:0]         ins_slot,
  input  logic [NUM_SRCS*TAG_W-1:0] ins_src_tag,
  input  logic [NUM_SRCS-1:0]       ins_src_rdy,
  input  logic                      ins_dst_valid,
  input  logic [TAG_W-1:0]          ins_dst_tag,
  input  logic                      cmp_valid,
  input  logic [TAG_W-1:0]          cmp_tag,
  input  logic [NUM_ENTRIES-1:0]    sq_mask,
  output logic [NUM_ENTRIES-1:0]    entry_ready
);
  logic [TAG_W-1:0]    src_tag [NUM_SRCS];
  logic [NUM_SRCS-1:0] src_avail;
  logic [NUM_SRCS-1:0] src_pend;
  logic                wake_hit;
  logic                dst_hit;

  for (genvar s = 0; s < NUM_SRCS; s++) begin : g_src
    assign src_tag[s]  = ins_src_tag[s*TAG_W +: TAG_W];
    assign src_pend[s] = !ins_src_rdy[s] && !src_avail[s];
  end

  assign wake_hit = cmp_valid && wt_tracked(32'(cmp_tag), NUM_PREGS);
  assign dst_hit  = ins_valid && ins_dst_valid &&
                    wt_tracked(32'(ins_dst_tag), NUM_PREGS);

  wt_scoreboard #(
    .NUM_PREGS(NUM_PREGS), .NUM_SRCS(NUM_SRCS), .TAG_W(TAG_W)
  ) sb_i (
    .clk       (clk),
    .rst       (rst),
    .look_tag  (src_tag),
    .look_avail(src_avail),
    .set_en    (wake_hit),
    .set_tag   (cmp_tag),
    .clr_en    (dst_hit),
    .clr_tag   (ins_dst_tag)
  );

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_slot
    wt_entry #(.NUM_SRCS(NUM_SRCS), .TAG_W(TAG_W)) slot_i (
      .clk     (clk),
      .rst     (rst),
      .ins_we  (ins_valid && (ins_slot == SLOT_W'(e))),
      .ins_tag (src_tag),
      .ins_pend(src_pend),
      .wake_en (wake_hit),
      .wake_tag(cmp_tag),
      .kill    (sq_mask[e]),
      .rdy_o   (entry_ready[e])
    );
  end

endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
  parameter int NUM_PREGS   = 64,
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_SRCS    = 2,
  parameter int TAG_W       = 7,
  localparam int SLOT_W     = $clog2(NUM_ENTRIES)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   ins_valid,
  input logic [SLOT_W-1:0]      ins_slot,
  input logic [NUM_SRCS-1:0]    ins_src_rdy,
  input logic                   cmp_valid,
  input logic [TAG_W-1:0]       cmp_tag,
  input logic [NUM_ENTRIES-1:0] sq_mask,
  input logic [NUM_ENTRIES-1:0] entry_ready
);

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (entry_ready == '0))
    else $error("reset did not clear ready flags");

  p_hint_ready_r2: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && (&ins_src_rdy)) |=> entry_ready[$past(ins_slot)])
    else $error("fully hinted insert not ready");

  p_untracked_inert_r5: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && (32'(cmp_tag) >= 32'(NUM_PREGS)) && !ins_valid &&
     (sq_mask == '0)) |=> $stable(entry_ready))
    else $error("untracked broadcast changed flags");

  p_quiet_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!ins_valid && !cmp_valid && (sq_mask == '0)) |=> $stable(entry_ready))
    else $error("flags changed without cause");

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_chk
    p_rise_cause_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(entry_ready[i]) |->
        ($past(ins_valid && (ins_slot == SLOT_W'(i))) || $past(cmp_valid)))
      else $error("slot %0d ready without insert or broadcast", i);

    p_squash_drops_r8: assert property (@(posedge clk) disable iff (rst)
      (sq_mask[i] && !(ins_valid && (ins_slot == SLOT_W'(i)))) |=>
        !entry_ready[i])
      else $error("squashed slot %0d still ready", i);
  end

endmodule

bind wakeup_tracker wt_checker #(
  .NUM_PREGS(NUM_PREGS), .NUM_ENTRIES(NUM_ENTRIES),
  .NUM_SRCS(NUM_SRCS), .TAG_W(TAG_W)
) chk_i (
  .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_slot(ins_slot),
  .ins_src_rdy(ins_src_rdy), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
  .sq_mask(sq_mask), .entry_ready(entry_ready)
);

// File: tb/wakeup_tracker_tb_top.sv
module wakeup_tracker_tb_top;
  localparam int NP = 64;
  localparam int NE = 16;
  localparam int NS = 2;
  localparam int TW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ins_valid = 1'b0;
  logic [3:0]    ins_slot = '0;
  logic [NS*TW-1:0] ins_src_tag = '0;
  logic [NS-1:0] ins_src_rdy = '0;
  logic          ins_dst_valid = 1'b0;
  logic [TW-1:0] ins_dst_tag = '0;
  logic          cmp_valid = 1'b0;
  logic [TW-1:0] cmp_tag = '0;
  logic [NE-1:0] sq_mask = '0;
  logic [NE-1:0] entry_ready;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  wakeup_tracker dut_i (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_slot(ins_slot),
    .ins_src_tag(ins_src_tag), .ins_src_rdy(ins_src_rdy),
    .ins_dst_valid(ins_dst_valid), .ins_dst_tag(ins_dst_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .sq_mask(sq_mask),
    .entry_ready(entry_ready)
  );

  // Behavioural reference model
  bit          m_sb [NP];
  bit          m_valid [NE];
  bit          m_pend [NE][NS];
  int          m_tag [NE][NS];
  bit          new_pend [NS];
  logic [NE-1:0] exp_ready = '0;

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NP; p++) m_sb[p] = 1'b0;
      for (int e = 0; e < NE; e++) begin
        m_valid[e] = 1'b0;
        for (int s = 0; s < NS; s++) m_pend[e][s] = 1'b0;
      end
      exp_ready = '0;
    end else begin
      for (int s = 0; s < NS; s++) begin
        int t;
        t = int'(ins_src_tag[s*TW +: TW]);
        new_pend[s] = ins_valid && !ins_src_rdy[s] && (t < NP) && !m_sb[t] &&
                      !(cmp_valid && int'(cmp_tag) == t);
      end
      for (int e = 0; e < NE; e++) begin
        if (sq_mask[e]) begin
          m_valid[e] = 1'b0;
          for (int s = 0; s < NS; s++) m_pend[e][s] = 1'b0;
        end else if (cmp_valid && int'(cmp_tag) < NP) begin
          for (int s = 0; s < NS; s++)
            if (m_tag[e][s] == int'(cmp_tag)) m_pend[e][s] = 1'b0;
        end
      end
      if (cmp_valid && int'(cmp_tag) < NP) m_sb[int'(cmp_tag)] = 1'b1;
      if (ins_valid && ins_dst_valid && int'(ins_dst_tag) < NP)
        m_sb[int'(ins_dst_tag)] = 1'b0;
      if (ins_valid) begin
        m_valid[ins_slot] = 1'b1;
        for (int s = 0; s < NS; s++) begin
          m_tag[ins_slot][s]  = int'(ins_src_tag[s*TW +: TW]);
          m_pend[ins_slot][s] = new_pend[s];
        end
      end
      for (int e = 0; e < NE; e++) begin
        bit any;
        any = 1'b0;
        for (int s = 0; s < NS; s++) any = any | m_pend[e][s];
        exp_ready[e] = m_valid[e] && !any;
      end
    end
  end

  task automatic idle_inputs();
    ins_valid = 1'b0; ins_dst_valid = 1'b0; cmp_valid = 1'b0; sq_mask = '0;
    ins_src_rdy = '0;
  endtask

  // Advance one clock and compare the whole flag vector at the falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (entry_ready !== exp_ready) begin
      fails++;
      $display("FAIL %s: entry_ready=%h expected=%h", cur_req, entry_ready, exp_ready);
    end
    idle_inputs();
  endtask

  task automatic ins(input int slot, input int t0, input int t1,
                     input bit r0, input bit r1, input bit dv, input int dt);
    ins_valid = 1'b1;
    ins_slot = 4'(slot);
    ins_src_tag = {TW'(t1), TW'(t0)};
    ins_src_rdy = {r1, r0};
    ins_dst_valid = dv;
    ins_dst_tag = TW'(dt);
  endtask

  task automatic bcast(input int t);
    cmp_valid = 1'b1;
    cmp_tag = TW'(t);
  endtask

  // Single-bit check of one slot against an explicit expectation.
  task automatic expect_slot(input int slot, input bit val);
    checks++;
    if (entry_ready[slot] !== val) begin
      fails++;
      $display("FAIL %s: slot %0d ready=%b expected=%b", cur_req, slot,
               entry_ready[slot], val);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    cur_req = "R1";
    tick(); tick();
    rst = 1'b0;
    tick();
    expect_slot(0, 1'b0);
    // R1: scoreboard starts not-available, so this insert waits
    ins(0, 5, 6, 0, 0, 0, 0); tick();
    expect_slot(0, 1'b0);

    cur_req = "R2";
    ins(1, 9, 10, 1, 1, 0, 0); tick();
    expect_slot(1, 1'b1);

    cur_req = "R7";
    bcast(5); tick();
    expect_slot(0, 1'b0);

    cur_req = "R6";
    bcast(6); tick();
    expect_slot(0, 1'b1);

    cur_req = "R3";
    ins(2, 5, 6, 0, 0, 0, 0); tick();
    expect_slot(2, 1'b1);

    cur_req = "R4";
    ins(3, 1, 2, 1, 1, 1, 5); tick();
    ins(4, 5, 9, 0, 1, 0, 0); tick();
    expect_slot(4, 1'b0);
    bcast(5); tick();
    expect_slot(4, 1'b1);
    ins(9, 0, 0, 1, 1, 1, 30); bcast(30); tick();
    ins(10, 30, 30, 0, 0, 0, 0); tick();
    expect_slot(10, 1'b0);

    cur_req = "R5";
    ins(5, 70, 64, 0, 0, 1, 100); tick();
    expect_slot(5, 1'b1);
    ins(6, 0, 1, 0, 0, 0, 0); tick();
    bcast(64); tick();
    expect_slot(6, 1'b0);
    bcast(65); tick();
    expect_slot(6, 1'b0);
    ins(7, 0, 9, 0, 1, 0, 0); tick();
    expect_slot(7, 1'b0);

    cur_req = "R8";
    bcast(0); sq_mask = 16'h0040; tick();
    expect_slot(6, 1'b0);
    expect_slot(7, 1'b1);
    bcast(1); tick();
    expect_slot(6, 1'b0);
    sq_mask = 16'h0002; ins(1, 40, 41, 1, 1, 0, 0); tick();
    expect_slot(1, 1'b1);
    sq_mask = 16'h0004; tick();
    expect_slot(2, 1'b0);

    cur_req = "R9";
    ins(8, 20, 21, 0, 1, 0, 0); bcast(20); tick();
    expect_slot(8, 1'b1);

    // Mixed traffic on a narrow tag range, compared every cycle
    cur_req = "R6";
    for (int c = 0; c < 600; c++) begin
      if ($urandom % 3 == 0)
        ins(int'($urandom % NE), int'($urandom % 72), int'($urandom % 72),
            bit'($urandom % 4 == 0), bit'($urandom % 4 == 0),
            bit'($urandom % 2), int'($urandom % 72));
      if ($urandom % 2 == 0) bcast(int'($urandom % 72));
      if ($urandom % 8 == 0) sq_mask = NE'(1) << ($urandom % NE);
      tick();
    end

    cur_req = "R1";
    rst = 1'b1; tick();
    rst = 1'b0; tick();
    expect_slot(0, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule